// File: doc/BRIEF.md
# Two-Level Decoded Integer ALU

This block is the arithmetic core of a simple single-cycle integer datapath, together with the small decoder that sits next to it. The main instruction decoder does not choose the exact arithmetic function. It sends only a 2-bit operation class. A local decoder combines that class with the 6-bit function field of the instruction and produces a 3-bit operation code. The datapath then computes a 32-bit result and a zero flag.

Memory-reference instructions need an address sum, so their class selects addition. Conditional branches compare two registers, so their class selects subtraction, and the branch logic reads the zero flag. Register-register instructions pass their function field through the second decode level.

The whole block is combinational. The most significant bit of the operation code does two jobs: it inverts operand B and it supplies the carry-in of the adder. Subtraction and signed compare therefore share one adder with addition.

Top module: `alu_two_level`

## Requirements
- R1: Class 2'b00 (memory reference) gives operation code 3'b010 (add), whatever the function field holds.
- R2: Class 2'b01 (branch) gives operation code 3'b110 (subtract), whatever the function field holds.
- R3: When class bit 1 is set, the function field is decoded: 6'b100000 gives add (010), 6'b100010 gives subtract (110), 6'b100100 gives AND (000), 6'b100101 gives OR (001), and 6'b101010 gives set-less-than (111).
- R4: When class bit 1 is set, any other function field value gives add (010).
- R5: Operation 000 returns the bitwise AND of A and B. Operation 001 returns their bitwise OR.
- R6: Operation 010 returns A+B modulo 2^32.
- R7: Operation 110 returns A−B modulo 2^32. It is formed as A + ~B + 1.
- R8: Operation 111 returns 1 in bit 0 when A is less than B as signed 32-bit numbers, and 0 otherwise. All other result bits are 0. The answer is correct even when A−B overflows.
- R9: The zero output is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opClass | input | 2 | Operation class from the main decoder |
| funcField | input | 6 | Function field of the instruction |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| aluCode | output | 3 | Decoded operation code |
| result | output | 32 | Arithmetic or logic result |
| zero | output | 1 | High when the result is all zeros |

## Verification
The decoder is driven with every class. Each fixed class is tried under several function fields, which shows the field is ignored there. Under the register class, every listed code is applied, plus unlisted ones next to them, which separates true matches from the add fallback.

The datapath is driven with random operands and with corner pairs: equal values, the most negative and most positive numbers, and all-ones. The signed-compare pairs are chosen so that the raw sign of A−B is wrong. This separates an overflow-corrected compare from a plain sign test. The equal-operand subtractions show the zero flag rising, and the nonzero results show it staying low.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DATA_W = 32;
  localparam int FUNC_W = 6;

  typedef enum logic [2:0] {
    OP_AND = 3'b000,
    OP_OR  = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b110,
    OP_SLT = 3'b111
  } aluOp_e;

  // strobes from control to datapath: invert B / carry in, and output unit select
  typedef struct packed {
    logic       invertB;
    logic [1:0] unitSel;
  } aluStrobes_t;

  localparam logic [1:0] UNIT_AND = 2'b00;
  localparam logic [1:0] UNIT_OR  = 2'b01;
  localparam logic [1:0] UNIT_SUM = 2'b10;
  localparam logic [1:0] UNIT_SLT = 2'b11;
endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
(
  input  logic [1:0]        opClass,
  input  logic [FUNC_W-1:0] funcField,
  output logic [2:0]        aluCode,
  output aluStrobes_t       strobes
);
  logic [2:0] fieldCode;

  always_comb begin
    unique case (funcField)
      6'b100000: fieldCode = OP_ADD;
      6'b100010: fieldCode = OP_SUB;
      6'b100100: fieldCode = OP_AND;
      6'b100101: fieldCode = OP_OR;
      6'b101010: fieldCode = OP_SLT;
      default:   fieldCode = OP_ADD;
    endcase
  end

  always_comb begin
    if (opClass[1])      aluCode = fieldCode;
    else if (opClass[0]) aluCode = OP_SUB;
    else                 aluCode = OP_ADD;
  end

  assign strobes.invertB = aluCode[2];
  assign strobes.unitSel = aluCode[1:0];

  always_comb begin
    if (opClass == 2'b00)
      AST_MEM_ADD: assert (aluCode == OP_ADD) else $error("class 00 not add"); // R1
    if (opClass == 2'b01)
      AST_BR_SUB: assert (aluCode == OP_SUB) else $error("class 01 not sub"); // R2
  end
endmodule

// File: rtl/alu_dp.sv
module alu_dp
  import alu_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluStrobes_t       strobes,
  output logic [DATA_W-1:0] result,
  output logic              zero
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] bMux;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] andOut;
  logic [DATA_W-1:0] orOut;
  logic              ovf;
  logic              lessBit;

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign bMux[i]   = opB[i] ^ strobes.invertB;
    assign andOut[i] = opA[i] & opB[i];
    assign orOut[i]  = opA[i] | opB[i];
  end

  assign sum     = opA + bMux + {{(DATA_W-1){1'b0}}, strobes.invertB};
  assign ovf     = (opA[MSB] == bMux[MSB]) && (sum[MSB] != opA[MSB]);
  assign lessBit = sum[MSB] ^ ovf;

  always_comb begin
    unique case (strobes.unitSel)
      UNIT_AND: result = andOut;
      UNIT_OR:  result = orOut;
      UNIT_SUM: result = sum;
      default:  result = {{(DATA_W-1){1'b0}}, lessBit};
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    if (strobes.unitSel == UNIT_SLT)
      AST_SLT_UPPER: assert (result[DATA_W-1:1] == '0) else $error("slt upper bits"); // R8
    if (strobes.unitSel == UNIT_SUM && strobes.invertB)
      AST_SUB_VALUE: assert (result == opA - opB) else $error("sub wrong"); // R7
  end
endmodule

// File: rtl/alu_two_level.sv
module alu_two_level
  import alu_pkg::*;
(
  input  logic [1:0]  opClass,
  input  logic [5:0]  funcField,
  input  logic [31:0] opA,
  input  logic [31:0] opB,
  output logic [2:0]  aluCode,
  output logic [31:0] result,
  output logic        zero
);
  aluStrobes_t strobes;

  alu_ctrl u_ctrl (
    .opClass(opClass), .funcField(funcField),
    .aluCode(aluCode), .strobes(strobes)
  );

  alu_dp u_dp (
    .opA(opA), .opB(opB), .strobes(strobes),
    .result(result), .zero(zero)
  );

  always_comb begin
    if (opClass == 2'b01)
      AST_BR_EQ: assert (zero == (opA == opB)) else $error("branch zero"); // R9
    if (aluCode == OP_ADD)
      AST_ADD_VALUE: assert (result == opA + opB) else $error("add wrong"); // R6
  end
endmodule

// File: tb/sim_alu_two_level.sv
module sim_alu_two_level;
  logic clk = 0;
  always #2.5 clk = ~clk;

  logic [1:0]  opClass;
  logic [5:0]  funcField;
  logic [31:0] opA, opB;
  logic [2:0]  aluCode;
  logic [31:0] result;
  logic        zero;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  alu_two_level u0 (.*);

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [1:0] c, logic [5:0] f, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    opClass = c; funcField = f; opA = a; opB = b;
    #1;
  endtask

  function automatic logic [31:0] refSlt(logic [31:0] a, logic [31:0] b);
    return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
  endfunction

  task automatic testReset();
    apply(2'b00, 6'd0, 32'd0, 32'd0);
    check("R1 idle code", {29'd0, aluCode}, 32'd2);
    check("R9 idle zero", {31'd0, zero}, 32'd1);
  endtask

  task automatic testFixedClasses();
    for (int f = 0; f < 64; f += 21) begin
      apply(2'b00, 6'(f), 32'd100, 32'd28);
      check("R1 mem code", {29'd0, aluCode}, 32'd2);
      check("R1 mem sum", result, 32'd128);
      apply(2'b01, 6'(f), 32'd100, 32'd28);
      check("R2 br code", {29'd0, aluCode}, 32'd6);
      check("R2 br diff", result, 32'd72);
    end
  endtask

  task automatic testFieldDecode();
    logic [5:0] codes[5] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010};
    logic [2:0] exps[5]  = '{3'b010, 3'b110, 3'b000, 3'b001, 3'b111};
    for (int i = 0; i < 5; i++) begin
      apply(2'b10, codes[i], 32'd5, 32'd3);
      check("R3 field code", {29'd0, aluCode}, {29'd0, exps[i]});
      apply(2'b11, codes[i], 32'd5, 32'd3);
      check("R3 field code class11", {29'd0, aluCode}, {29'd0, exps[i]});
    end
    apply(2'b10, 6'b100001, 32'd5, 32'd3);
    check("R4 unknown 100001", {29'd0, aluCode}, 32'd2);
    check("R4 unknown sum", result, 32'd8);
    apply(2'b10, 6'b101011, 32'd5, 32'd3);
    check("R4 unknown 101011", {29'd0, aluCode}, 32'd2);
    apply(2'b10, 6'b000000, 32'd5, 32'd3);
    check("R4 unknown 000000", {29'd0, aluCode}, 32'd2);
  endtask

  task automatic testLogicArith();
    logic [31:0] a, b;
    for (int n = 0; n < 40; n++) begin
      a = $urandom; b = $urandom;
      apply(2'b10, 6'b100100, a, b); check("R5 and", result, a & b);
      apply(2'b10, 6'b100101, a, b); check("R5 or", result, a | b);
      apply(2'b10, 6'b100000, a, b); check("R6 add", result, a + b);
      apply(2'b10, 6'b100010, a, b); check("R7 sub", result, a - b);
      check("R9 zero on sub", {31'd0, zero}, {31'd0, (a == b)});
      apply(2'b10, 6'b101010, a, b); check("R8 slt", result, refSlt(a, b));
    end
    apply(2'b10, 6'b100000, 32'hFFFF_FFFF, 32'd1);
    check("R6 wrap", result, 32'd0);
    check("R9 zero after wrap", {31'd0, zero}, 32'd1);
  endtask

  task automatic testSltCorners();
    logic [31:0] as[6] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'd0, 32'd7, 32'h8000_0000};
    logic [31:0] bs[6] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'd0, 32'hFFFF_FFFF, 32'd7, 32'd1};
    for (int i = 0; i < 6; i++) begin
      apply(2'b10, 6'b101010, as[i], bs[i]);
      check("R8 slt corner", result, refSlt(as[i], bs[i]));
    end
    apply(2'b01, 6'd0, 32'h1234_5678, 32'h1234_5678);
    check("R9 branch equal", {31'd0, zero}, 32'd1);
    apply(2'b01, 6'd0, 32'h1234_5678, 32'h1234_5679);
    check("R9 branch differ", {31'd0, zero}, 32'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    testReset();
    testFixedClasses();
    testFieldDecode();
    testLogicArith();
    testSltCorners();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule